// File: doc/BRIEF.md
# Watchdog Reset Supervisor with Serial Configuration

This block supervises a host processor's reset line. It keeps the reset output active during power-up and while a low-supply flag is raised, and for a fixed hold time after either condition goes away. A watchdog timer runs alongside it. The host restarts the watchdog by making any transition on a pin that also serves as the active-low chip select of a small serial command port. If the host stops toggling that pin for longer than the chosen timeout, the block asserts reset and then runs the same hold time.

The timeout (200 ms, 600 ms or 1400 ms, or off) sits in a status byte that is read and written over SPI mode 0. A write only takes effect after a write-enable command has set a guard latch. The timeout register models non-volatile storage: only the block reset `rst` (first power-on) returns it to its default. Supply dips and watchdog resets leave it as it is. A prescaler derived from `CLK_HZ` turns the system clock into a 1 ms tick, and every delay counts that tick. The supply comparator lives outside the block and delivers a synchronous flag.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `reset_o` is 1. After `rst` falls, `reset_o` stays 1 for HOLD_MS (default 200) ms ticks and then drops to 0. It is still 1 at 199 ms and is 0 by 200 ms plus a few clocks.
- R2: When `low_supply_i` is 1, `reset_o` is 1 from the next clock onward and stays 1 while the flag is held. After the flag clears, `reset_o` is released only after the same HOLD_MS delay.
- R3: When the watchdog reaches its timeout with no transition on `csn_wdi_i`, `reset_o` asserts and then runs the HOLD_MS hold before release.
- R4: Any edge on `csn_wdi_i`, rising or falling, restarts the watchdog count. This includes edges with no SCK activity between them.
- R5: Status bits 5:4 select the timeout: 2'b00 = 1400 ms, 2'b01 = 600 ms, 2'b10 = 200 ms, 2'b11 = watchdog off. With 2'b11 the watchdog never asserts reset.
- R6: The serial port follows SPI mode 0: SCK idles low, MOSI is sampled on rising SCK, MOSI bits are sent MSB first, and MISO changes on falling SCK.
  - Opcode 0x05 returns the status byte MSB first in the following byte(s). The status byte carries the timeout select in bits 5:4 and the write-enable latch in bit 1. All other bits read 0.
  - `miso_o` is 0 while `csn_wdi_i` is high.
- R7: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x01 followed by a data byte copies data bits 5:4 into the timeout select, but only when the latch is set. Otherwise the byte is ignored.
- R8: The write-enable latch clears as soon as a status write completes. It is also held clear whenever `reset_o` is 1.
- R9: The timeout select is 2'b00 after `rst`. Low-supply resets and watchdog resets do not change it.
- R10: The watchdog does not count while `reset_o` is 1. Its count starts from zero when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| low_supply_i | input | 1 | Synchronous low-supply flag from the external comparator |
| sck_i | input | 1 | Serial clock, idle low |
| csn_wdi_i | input | 1 | Active-low chip select; every edge also restarts the watchdog |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out, 0 when deselected |
| reset_o | output | 1 | Active-high reset to the host |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that SCK is much slower than the system clock, so that every SCK edge is seen as its own clock-level transition. The bench drives SCK with half periods of four clocks. It changes MOSI and the chip select only while SCK is low, and it changes `low_supply_i` only on falling clock edges. The ms tick runs freely, so every delay is checked against a window one tick wide instead of a single cycle.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [1:0] {
        TSEL_LONG  = 2'b00,
        TSEL_MID   = 2'b01,
        TSEL_SHORT = 2'b10,
        TSEL_OFF   = 2'b11
    } tsel_e;

    typedef enum logic [1:0] {
        SPI_CMD,
        SPI_WDATA,
        SPI_READ,
        SPI_IGNORE
    } spi_st_e;

    typedef struct packed {
        logic [1:0] rsvd_hi;
        tsel_e      tsel;
        logic [1:0] rsvd_mid;
        logic       wel;
        logic       rsvd_lo;
    } status_t;

    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD   = 8'h05;
    localparam logic [7:0] OP_STAT_WR   = 8'h01;

    function automatic status_t pack_status(tsel_e t, logic w);
        status_t s;
        s      = '0;
        s.tsel = t;
        s.wel  = w;
        return s;
    endfunction

endpackage

// File: rtl/rsup_ms_tick.sv
module rsup_ms_tick #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned DIV = (CLK_HZ / 1000 < 2) ? 2 : CLK_HZ / 1000;
    localparam int unsigned CW  = $clog2(DIV);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= (cnt == CW'(DIV - 1));
            cnt    <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rsup_spi_port.sv
module rsup_spi_port
    import rsup_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sck_i,
    input  logic  csn_i,
    input  logic  mosi_i,
    input  logic  hold_i,
    output logic  miso_o,
    output tsel_e tsel_o,
    output logic  wel_o,
    output logic  kick_o
);
    logic      sck_q, csn_q;
    logic      sck_rise, sck_fall, cs_act, byte_done;
    logic [2:0] bit_cnt;
    logic [6:0] in_sr;
    logic [7:0] out_sr, rx_byte;
    logic      miso_q, wel_q;
    tsel_e     tsel_q;
    spi_st_e   state;
    status_t   stat;

    assign cs_act    = ~csn_i;
    assign sck_rise  = sck_i & ~sck_q;
    assign sck_fall  = ~sck_i & sck_q;
    assign byte_done = cs_act & sck_rise & (bit_cnt == 3'd7);
    assign rx_byte   = {in_sr, mosi_i};
    assign kick_o    = csn_i ^ csn_q;

    always_comb stat = pack_status(tsel_q, wel_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            csn_q   <= 1'b1;
            bit_cnt <= '0;
            in_sr   <= '0;
            out_sr  <= '0;
            miso_q  <= 1'b0;
            wel_q   <= 1'b0;
            tsel_q  <= TSEL_LONG;
            state   <= SPI_CMD;
        end else begin
            sck_q <= sck_i;
            csn_q <= csn_i;
            if (!cs_act) begin
                state   <= SPI_CMD;
                bit_cnt <= '0;
                miso_q  <= 1'b0;
            end else begin
                if (sck_rise) begin
                    in_sr   <= {in_sr[5:0], mosi_i};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (byte_done) begin
                    case (state)
                        SPI_CMD: begin
                            case (rx_byte)
                                OP_LATCH_SET: begin
                                    wel_q <= 1'b1;
                                    state <= SPI_IGNORE;
                                end
                                OP_LATCH_CLR: begin
                                    wel_q <= 1'b0;
                                    state <= SPI_IGNORE;
                                end
                                OP_STAT_RD: begin
                                    out_sr <= stat;
                                    state  <= SPI_READ;
                                end
                                OP_STAT_WR: state <= SPI_WDATA;
                                default:    state <= SPI_IGNORE;
                            endcase
                        end
                        SPI_WDATA: begin
                            if (wel_q) begin
                                tsel_q <= tsel_e'(rx_byte[5:4]);
                                wel_q  <= 1'b0;
                            end
                            state <= SPI_IGNORE;
                        end
                        default: ;
                    endcase
                end
                if (sck_fall && state == SPI_READ) begin
                    miso_q <= out_sr[7];
                    out_sr <= {out_sr[6:0], out_sr[7]};
                end
            end
            if (hold_i) wel_q <= 1'b0;
        end
    end

    assign miso_o = miso_q;
    assign tsel_o = tsel_q;
    assign wel_o  = wel_q;
endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog
    import rsup_pkg::*;
#(
    parameter int unsigned SHORT_MS = 200,
    parameter int unsigned MID_MS   = 600,
    parameter int unsigned LONG_MS  = 1400
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  kick_i,
    input  logic  hold_i,
    input  tsel_e tsel_i,
    output logic  expire_o
);
    localparam int unsigned CW = $clog2(LONG_MS + 1);

    logic [CW-1:0] cnt, lim;

    always_comb begin
        case (tsel_i)
            TSEL_SHORT: lim = CW'(SHORT_MS - 1);
            TSEL_MID:   lim = CW'(MID_MS - 1);
            default:    lim = CW'(LONG_MS - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || hold_i || kick_i || tsel_i == TSEL_OFF) begin
            cnt      <= '0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (tick_i) begin
                if (cnt >= lim) begin
                    expire_o <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rsup_reset_gen.sv
module rsup_reset_gen #(
    parameter int unsigned HOLD_MS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic low_i,
    input  logic expire_i,
    output logic reset_o
);
    localparam int unsigned HW = $clog2(HOLD_MS + 1);

    logic [HW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst || low_i || expire_i) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick_i) begin
            if (cnt == HW'(HOLD_MS - 1)) active <= 1'b0;
            else                         cnt    <= cnt + 1'b1;
        end
    end

    assign reset_o = active;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsup_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned HOLD_MS     = 200,
    parameter int unsigned WD_SHORT_MS = 200,
    parameter int unsigned WD_MID_MS   = 600,
    parameter int unsigned WD_LONG_MS  = 1400
) (
    input  logic clk,
    input  logic rst,
    input  logic low_supply_i,
    input  logic sck_i,
    input  logic csn_wdi_i,
    input  logic mosi_i,
    output logic miso_o,
    output logic reset_o
);
    logic  tick, kick, wel, wd_expire;
    tsel_e tsel;

    rsup_ms_tick #(.CLK_HZ(CLK_HZ)) tick_i (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    rsup_spi_port spi_i (
        .clk(clk), .rst(rst), .sck_i(sck_i), .csn_i(csn_wdi_i),
        .mosi_i(mosi_i), .hold_i(reset_o), .miso_o(miso_o),
        .tsel_o(tsel), .wel_o(wel), .kick_o(kick)
    );

    rsup_watchdog #(
        .SHORT_MS(WD_SHORT_MS), .MID_MS(WD_MID_MS), .LONG_MS(WD_LONG_MS)
    ) wdog_i (
        .clk(clk), .rst(rst), .tick_i(tick), .kick_i(kick),
        .hold_i(reset_o), .tsel_i(tsel), .expire_o(wd_expire)
    );

    rsup_reset_gen #(.HOLD_MS(HOLD_MS)) rgen_i (
        .clk(clk), .rst(rst), .tick_i(tick), .low_i(low_supply_i),
        .expire_i(wd_expire), .reset_o(reset_o)
    );
endmodule

// File: rtl/rsup_checker.sv
module rsup_checker
    import rsup_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  low_supply_i,
    input logic  reset_o,
    input logic  wd_expire,
    input logic  wel,
    input tsel_e tsel
);
    p_low_holds_r2: assert property (@(posedge clk) disable iff (rst)
        low_supply_i |=> reset_o);

    p_release_clean_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_o) |-> !$past(low_supply_i));

    p_expire_resets_r3: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> reset_o);

    p_off_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (tsel == TSEL_OFF && $past(tsel) == TSEL_OFF) |-> !wd_expire);

    p_latch_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        reset_o |=> !wel);

    p_guarded_write_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(tsel) |-> $past(wel));

    p_no_count_in_reset_r10: assert property (@(posedge clk) disable iff (rst)
        reset_o |=> !wd_expire);
endmodule

bind rst_supervisor rsup_checker chk_i (
    .clk(clk), .rst(rst), .low_supply_i(low_supply_i), .reset_o(reset_o),
    .wd_expire(wd_expire), .wel(wel), .tsel(tsel)
);

// File: tb/rst_supervisor_tb_top.sv
`timescale 1ns/1ps
module rst_supervisor_tb_top;
    localparam int T = 8;  // clock cycles per ms tick with CLK_HZ = 8000
    localparam int NV = 12;
    // {opcode, data byte, expected status byte after the command}
    localparam logic [23:0] VEC [NV] = '{
        {8'h01, 8'h30, 8'h00},
        {8'h06, 8'h00, 8'h02},
        {8'h04, 8'h00, 8'h00},
        {8'h06, 8'h00, 8'h02},
        {8'h01, 8'h10, 8'h10},
        {8'h01, 8'h20, 8'h10},
        {8'h06, 8'h00, 8'h12},
        {8'h01, 8'h30, 8'h30},
        {8'h06, 8'h00, 8'h32},
        {8'h01, 8'hFF, 8'h30},
        {8'h06, 8'h00, 8'h32},
        {8'h01, 8'h20, 8'h20}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic low = 1'b0;
    logic sck = 1'b0;
    logic csn = 1'b1;
    logic mosi = 1'b0;
    logic miso, rst_out;
    int   n_checks = 0;
    int   n_fail = 0;
    logic [7:0] st;

    always #2.5 clk = ~clk;

    rst_supervisor #(.CLK_HZ(8000)) dut_i (
        .clk(clk), .rst(rst), .low_supply_i(low), .sck_i(sck),
        .csn_wdi_i(csn), .mosi_i(mosi), .miso_o(miso), .reset_o(rst_out)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) mosi = tx[i];
            wait_cyc(3);
            rx[i] = miso;
            sck = 1'b1;
            wait_cyc(4);
            sck = 1'b0;
        end
    endtask

    task automatic spi_cmd(input logic [7:0] op, input bit with_data, input logic [7:0] data);
        logic [7:0] dummy;
        @(negedge clk) csn = 1'b0;
        wait_cyc(4);
        spi_byte(op, dummy);
        if (with_data) spi_byte(data, dummy);
        wait_cyc(4);
        csn = 1'b1;
        wait_cyc(4);
    endtask

    task automatic read_status(output logic [7:0] s);
        logic [7:0] dummy;
        @(negedge clk) csn = 1'b0;
        wait_cyc(4);
        spi_byte(8'h05, dummy);
        spi_byte(8'h00, s);
        wait_cyc(4);
        csn = 1'b1;
        wait_cyc(4);
    endtask

    task automatic set_tsel(input logic [1:0] t);
        spi_cmd(8'h06, 1'b0, 8'h00);
        spi_cmd(8'h01, 1'b1, {2'b00, t, 4'b0000});
    endtask

    task automatic kick();
        @(negedge clk) csn = 1'b0;
        wait_cyc(2);
        csn = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: bench did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] op, data, exp, s2;
        wait_cyc(10);
        check_eq("R1 reset asserted during rst", rst_out, 1);
        check_eq("R6 miso low when deselected", miso, 0);
        rst = 1'b0;

        // R1 power-up hold
        wait_cyc(199 * T - 2);
        check_eq("R1 still held at 199ms", rst_out, 1);
        wait_cyc(T + 8);
        check_eq("R1 released after 200ms", rst_out, 0);
        read_status(st);
        check_eq("R9 default status after rst", st, 8'h00);

        // Command table: R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            op   = VEC[i][23:16];
            data = VEC[i][15:8];
            exp  = VEC[i][7:0];
            spi_cmd(op, op == 8'h01, data);
            read_status(st);
            check_eq($sformatf("R7/R8 vector %0d status", i), st, exp);
        end
        check_eq("R6 miso low after read", miso, 0);

        // R6 repeated status byte within one read
        @(negedge clk) csn = 1'b0;
        wait_cyc(4);
        spi_byte(8'h05, st);
        spi_byte(8'h00, st);
        spi_byte(8'h00, s2);
        wait_cyc(4);
        csn = 1'b1;
        check_eq("R6 second status byte", s2, 8'h20);

        // R4 kicks keep the 200ms watchdog quiet
        for (int k = 0; k < 4; k++) begin
            wait_cyc(150 * T);
            kick();
            check_eq("R4 no reset with regular kicks", rst_out, 0);
        end

        // R3 expiry, WREN right before is last transition
        spi_cmd(8'h06, 1'b0, 8'h00);
        wait_cyc(199 * T - 16);
        check_eq("R3 no reset before 200ms timeout", rst_out, 0);
        wait_cyc(T + 16);
        check_eq("R3 reset after 200ms timeout", rst_out, 1);
        read_status(st);
        check_eq("R8 latch cleared by reset, R9 select kept", st, 8'h20);
        wait_cyc(150 * T);
        check_eq("R3 hold after watchdog reset", rst_out, 1);
        wait_cyc(52 * T);
        check_eq("R3 released after hold", rst_out, 0);

        // R5 mid timeout
        set_tsel(2'b01);
        wait_cyc(599 * T - 16);
        check_eq("R5 no reset before 600ms", rst_out, 0);
        wait_cyc(T + 16);
        check_eq("R5 reset after 600ms", rst_out, 1);
        wait_cyc(202 * T);

        // R5 long timeout
        set_tsel(2'b00);
        wait_cyc(1399 * T - 16);
        check_eq("R5 no reset before 1400ms", rst_out, 0);
        wait_cyc(T + 16);
        check_eq("R5 reset after 1400ms", rst_out, 1);
        wait_cyc(202 * T);

        // R5 off
        set_tsel(2'b11);
        wait_cyc(1500 * T);
        check_eq("R5 watchdog off never resets", rst_out, 0);

        // R2 low supply, R9 retention, R10 no counting while held
        set_tsel(2'b10);
        @(negedge clk) low = 1'b1;
        wait_cyc(2);
        check_eq("R2 reset follows low supply", rst_out, 1);
        wait_cyc(250 * T);
        check_eq("R2 held while supply low", rst_out, 1);
        @(negedge clk) low = 1'b0;
        wait_cyc(199 * T - 1);
        check_eq("R2 held 199ms after recovery", rst_out, 1);
        wait_cyc(T + 5);
        check_eq("R2 released after recovery hold", rst_out, 0);
        wait_cyc(150 * T);
        check_eq("R10 watchdog restarts at release", rst_out, 0);
        read_status(st);
        check_eq("R9 select kept across low supply", st, 8'h20);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule